// File: doc/BRIEF.md
# Delay-Slot Fetch Address Sequencer with Micro-Op Index

This block keeps the program-counter state for a processor that has fixed-length instructions, a single branch delay slot and macro-instructions broken into micro-ops. It holds a three-entry address window: the instruction now executing, the one after it (the delay slot when a branch is pending), and the one after that. Beside the window it holds a pair of micro-op indices, the current one and the next one.

A controller drives one-cycle commands. A load redirects the whole window to a new address. An advance shifts the window by one instruction. A micro-advance steps the micro-op index inside a macro-instruction. A micro-end finishes the macro-instruction. A redirect write replaces only the furthest address, so a taken branch lands after the delay-slot instruction has run. All five state values are presented every cycle, together with a combinational flag that marks non-sequential control flow.

Top module: `pc_window_seq`

## Requirements
- R1: A load of address A sets current to A, next to A+S and after-next to A+2S, where S is the instruction size in bytes. All sums wrap modulo 2^ADDR_W.
- R2: A load also sets the current micro-index to 0 and the next micro-index to 1.
- R3: An advance puts the old next into current and the old after-next into next, and sets after-next to the old after-next plus S. The micro-indices do not change.
- R4: A micro-advance puts the old next micro-index into current and sets next to the old next plus 1, modulo 2^UPC_W. The three addresses do not change.
- R5: A micro-end shifts the address window exactly as an advance does and returns the micro-indices to 0 and 1.
- R6: `branching` is 0 only when after-next equals next+S, next equals current+S or current+2S, and next micro-index equals current micro-index plus 1. Otherwise it is 1. It is computed from the registered state in the same cycle.
- R7: A redirect write without a load replaces only the after-next address with `redir_addr`. If an advance or micro-end happens in the same cycle, the window shifts first and `redir_addr` goes into the new after-next slot in place of old after-next plus S.
- R8: When several commands arrive in one cycle, load wins over micro-end, micro-end wins over advance, and advance wins over micro-advance. A command that loses has no effect. A redirect write is ignored when a load is present.
- R9: An active-low asynchronous reset acts as a load of RESET_VEC. A cycle with no command leaves all five state values unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_en | input | 1 | Redirect the whole window to `load_addr` |
| load_addr | input | ADDR_W | Target address of a load |
| adv_en | input | 1 | Advance by one instruction |
| uadv_en | input | 1 | Step the micro-op index |
| uend_en | input | 1 | End the macro-instruction |
| redir_en | input | 1 | Write the after-next address |
| redir_addr | input | ADDR_W | Taken-branch target for the after-next slot |
| cur_pc | output | ADDR_W | Address of the instruction now executing |
| nxt_pc | output | ADDR_W | Address of the next instruction (the delay slot) |
| after_pc | output | ADDR_W | Address of the instruction after next |
| cur_upc | output | UPC_W | Current micro-op index |
| nxt_upc | output | UPC_W | Next micro-op index |
| branching | output | 1 | Flow is not sequential |

## Verification
The bound checker checks every cycle how each winning command changes the state. It covers the load values, the window shift on advance and micro-end, the micro-index step, the redirect slot, idle hold, and the fact that a load always leaves the flag clear. Some things only the bench's scenarios can show. These are the flag's value after a taken branch moves through the delay slot, wrapping of addresses and micro-indices, and the losing side of every command combination. The bench shows them by sweeping all load addresses and all 32 command combinations against an arithmetic model.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

   // Winning command of a cycle after priority resolution
   typedef enum logic [2:0] {
      OP_HOLD = 3'd0,
      OP_LOAD = 3'd1,
      OP_UEND = 3'd2,
      OP_ADV  = 3'd3,
      OP_UADV = 3'd4
   } pcseq_op_e;

   // Number of address slots in the delay-slot window
   localparam int unsigned WIN_SLOTS = 3;

   // True when the window shifts by one instruction
   function automatic logic op_shifts(input pcseq_op_e op);
      return (op == OP_ADV) || (op == OP_UEND);
   endfunction

endpackage

// File: rtl/pcseq_cmd_arb.sv
module pcseq_cmd_arb
   import pcseq_pkg::*;
(
   input  logic      load_en,
   input  logic      uend_en,
   input  logic      adv_en,
   input  logic      uadv_en,
   output pcseq_op_e op
);

   // Fixed priority: load, micro-end, advance, micro-advance
   always_comb begin
      if (load_en)       op = OP_LOAD;
      else if (uend_en)  op = OP_UEND;
      else if (adv_en)   op = OP_ADV;
      else if (uadv_en)  op = OP_UADV;
      else               op = OP_HOLD;
   end

endmodule

// File: rtl/pcseq_addr_window.sv
module pcseq_addr_window
   import pcseq_pkg::*;
#(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned INST_BYTES = 4,
   parameter logic [ADDR_W-1:0] RESET_VEC = '0
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  pcseq_op_e                     op,
   input  logic [ADDR_W-1:0]             load_addr,
   input  logic                          redir_en,
   input  logic [ADDR_W-1:0]             redir_addr,
   output logic [WIN_SLOTS-1:0][ADDR_W-1:0] slot_q
);

   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INST_BYTES);
   localparam int unsigned       LAST = WIN_SLOTS - 1;

   logic shift;
   assign shift = op_shifts(op);

   for (genvar i = 0; i < WIN_SLOTS; i++) begin : g_slot
      localparam logic [ADDR_W-1:0] OFS = ADDR_W'(i * INST_BYTES);

      logic [ADDR_W-1:0] q;
      logic [ADDR_W-1:0] d;

      if (i < LAST) begin : g_inner
         // Inner slots take their successor on a shift
         always_comb begin
            if (op == OP_LOAD)  d = load_addr + OFS;
            else if (shift)     d = slot_q[i+1];
            else                d = q;
         end
      end else begin : g_tail
         // Tail slot extends the run by one instruction or takes a branch target
         always_comb begin
            if (op == OP_LOAD)  d = load_addr + OFS;
            else if (shift)     d = redir_en ? redir_addr : (q + STEP);
            else if (redir_en)  d = redir_addr;
            else                d = q;
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= RESET_VEC + OFS;
         else        q <= d;
      end

      assign slot_q[i] = q;
   end

endmodule

// File: rtl/pcseq_upc_pair.sv
module pcseq_upc_pair
   import pcseq_pkg::*;
#(
   parameter int unsigned UPC_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  pcseq_op_e        op,
   output logic [UPC_W-1:0] cur_q,
   output logic [UPC_W-1:0] nxt_q
);

   localparam logic [UPC_W-1:0] ONE = UPC_W'(1);

   logic [UPC_W-1:0] cur_d;
   logic [UPC_W-1:0] nxt_d;

   always_comb begin
      unique case (op)
         OP_LOAD, OP_UEND: begin
            cur_d = '0;
            nxt_d = ONE;
         end
         OP_UADV: begin
            cur_d = nxt_q;
            nxt_d = nxt_q + ONE;
         end
         default: begin
            cur_d = cur_q;
            nxt_d = nxt_q;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q <= '0;
         nxt_q <= ONE;
      end else begin
         cur_q <= cur_d;
         nxt_q <= nxt_d;
      end
   end

endmodule

// File: rtl/pcseq_flow_detect.sv
module pcseq_flow_detect
   import pcseq_pkg::*;
#(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned INST_BYTES = 4,
   parameter int unsigned UPC_W      = 8
) (
   input  logic [WIN_SLOTS-1:0][ADDR_W-1:0] slot_q,
   input  logic [UPC_W-1:0]                 cur_upc,
   input  logic [UPC_W-1:0]                 nxt_upc,
   output logic                             branching
);

   localparam logic [ADDR_W-1:0] STEP  = ADDR_W'(INST_BYTES);
   localparam logic [ADDR_W-1:0] STEP2 = ADDR_W'(2 * INST_BYTES);

   logic tail_seq;
   logic mid_one;
   logic mid_two;
   logic upc_seq;

   // Each pair of neighbouring slots is compared on its own
   assign tail_seq = (slot_q[2] == slot_q[1] + STEP);
   assign mid_one  = (slot_q[1] == slot_q[0] + STEP);
   assign mid_two  = (slot_q[1] == slot_q[0] + STEP2);
   assign upc_seq  = (nxt_upc == cur_upc + UPC_W'(1));

   assign branching = !(tail_seq && (mid_one || mid_two) && upc_seq);

endmodule

// File: rtl/pc_window_seq.sv
module pc_window_seq
   import pcseq_pkg::*;
#(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned INST_BYTES = 4,
   parameter int unsigned UPC_W      = 8,
   parameter logic [ADDR_W-1:0] RESET_VEC = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_en,
   input  logic [ADDR_W-1:0] load_addr,
   input  logic              adv_en,
   input  logic              uadv_en,
   input  logic              uend_en,
   input  logic              redir_en,
   input  logic [ADDR_W-1:0] redir_addr,
   output logic [ADDR_W-1:0] cur_pc,
   output logic [ADDR_W-1:0] nxt_pc,
   output logic [ADDR_W-1:0] after_pc,
   output logic [UPC_W-1:0]  cur_upc,
   output logic [UPC_W-1:0]  nxt_upc,
   output logic              branching
);

   // Elaboration-time parameter checks
   if (ADDR_W < 4 || ADDR_W > 64) begin : g_bad_addr_w
      $error("pc_window_seq: ADDR_W must lie in 4..64");
   end
   if (INST_BYTES < 1) begin : g_bad_inst
      $error("pc_window_seq: INST_BYTES must be at least 1");
   end
   if (UPC_W < 1) begin : g_bad_upc_w
      $error("pc_window_seq: UPC_W must be at least 1");
   end

   pcseq_op_e                        op;
   logic [WIN_SLOTS-1:0][ADDR_W-1:0] slots;

   pcseq_cmd_arb u_arb (
      .load_en (load_en),
      .uend_en (uend_en),
      .adv_en  (adv_en),
      .uadv_en (uadv_en),
      .op      (op)
   );

   pcseq_addr_window #(
      .ADDR_W     (ADDR_W),
      .INST_BYTES (INST_BYTES),
      .RESET_VEC  (RESET_VEC)
   ) u_win (
      .clk        (clk),
      .rst_n      (rst_n),
      .op         (op),
      .load_addr  (load_addr),
      .redir_en   (redir_en),
      .redir_addr (redir_addr),
      .slot_q     (slots)
   );

   pcseq_upc_pair #(
      .UPC_W (UPC_W)
   ) u_upc (
      .clk   (clk),
      .rst_n (rst_n),
      .op    (op),
      .cur_q (cur_upc),
      .nxt_q (nxt_upc)
   );

   pcseq_flow_detect #(
      .ADDR_W     (ADDR_W),
      .INST_BYTES (INST_BYTES),
      .UPC_W      (UPC_W)
   ) u_flow (
      .slot_q    (slots),
      .cur_upc   (cur_upc),
      .nxt_upc   (nxt_upc),
      .branching (branching)
   );

   assign cur_pc   = slots[0];
   assign nxt_pc   = slots[1];
   assign after_pc = slots[2];

endmodule

// File: rtl/pcseq_checker.sv
module pcseq_checker #(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned INST_BYTES = 4,
   parameter int unsigned UPC_W      = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              load_en,
   input logic [ADDR_W-1:0] load_addr,
   input logic              adv_en,
   input logic              uadv_en,
   input logic              uend_en,
   input logic              redir_en,
   input logic [ADDR_W-1:0] redir_addr,
   input logic [ADDR_W-1:0] cur_pc,
   input logic [ADDR_W-1:0] nxt_pc,
   input logic [ADDR_W-1:0] after_pc,
   input logic [UPC_W-1:0]  cur_upc,
   input logic [UPC_W-1:0]  nxt_upc,
   input logic              branching
);

   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INST_BYTES);

   logic only_adv;
   logic only_uadv;
   logic idle;
   assign only_adv  = adv_en && !load_en && !uend_en;
   assign only_uadv = uadv_en && !load_en && !uend_en && !adv_en;
   assign idle      = !load_en && !uend_en && !adv_en && !uadv_en && !redir_en;

   AST_LOAD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      load_en |=> (cur_pc == $past(load_addr)) && (nxt_pc == $past(load_addr) + STEP)) // R1
      else $error("AST_LOAD_ADDR");

   AST_LOAD_UPC: assert property (@(posedge clk) disable iff (!rst_n)
      load_en |=> (cur_upc == '0) && (nxt_upc == UPC_W'(1))) // R2
      else $error("AST_LOAD_UPC");

   AST_ADV_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
      only_adv |=> (cur_pc == $past(nxt_pc)) && (nxt_pc == $past(after_pc))
                   && $stable(cur_upc) && $stable(nxt_upc)) // R3
      else $error("AST_ADV_SHIFT");

   AST_UADV_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      only_uadv |=> (cur_upc == $past(nxt_upc)) && $stable(cur_pc) && $stable(nxt_pc)) // R4
      else $error("AST_UADV_STEP");

   AST_UEND_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      (uend_en && !load_en) |=> (cur_pc == $past(nxt_pc)) && (cur_upc == '0)
                                && (nxt_upc == UPC_W'(1))) // R5
      else $error("AST_UEND_RESET");

   AST_LOAD_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
      load_en |=> !branching) // R6
      else $error("AST_LOAD_SEQ");

   AST_REDIR_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
      (redir_en && !load_en) |=> (after_pc == $past(redir_addr))) // R7
      else $error("AST_REDIR_TAIL");

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      idle |=> $stable(cur_pc) && $stable(nxt_pc) && $stable(after_pc)
               && $stable(cur_upc) && $stable(nxt_upc)) // R9
      else $error("AST_IDLE_HOLD");

endmodule

bind pc_window_seq pcseq_checker #(
   .ADDR_W     (ADDR_W),
   .INST_BYTES (INST_BYTES),
   .UPC_W      (UPC_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .load_en    (load_en),
   .load_addr  (load_addr),
   .adv_en     (adv_en),
   .uadv_en    (uadv_en),
   .uend_en    (uend_en),
   .redir_en   (redir_en),
   .redir_addr (redir_addr),
   .cur_pc     (cur_pc),
   .nxt_pc     (nxt_pc),
   .after_pc   (after_pc),
   .cur_upc    (cur_upc),
   .nxt_upc    (nxt_upc),
   .branching  (branching)
);

// File: tb/tb_pc_window_seq.sv
module tb_pc_window_seq;

   localparam int CLK_PERIOD = 10;
   localparam int AW = 8;
   localparam int SB = 2;
   localparam int UW = 3;
   localparam logic [AW-1:0] RV = 8'h10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          load_en = 1'b0, adv_en = 1'b0, uadv_en = 1'b0, uend_en = 1'b0, redir_en = 1'b0;
   logic [AW-1:0] load_addr = '0, redir_addr = '0;
   logic [AW-1:0] cur_pc, nxt_pc, after_pc;
   logic [UW-1:0] cur_upc, nxt_upc;
   logic          branching;

   int vectors = 0;
   int fails   = 0;
   bit done    = 1'b0;

   // Reference state
   logic [AW-1:0] m_cur, m_nxt, m_aft;
   logic [UW-1:0] m_cu, m_nu;
   logic [15:0]   seed = 16'hACE1;

   always #(CLK_PERIOD/2) clk = ~clk;

   pc_window_seq #(
      .ADDR_W(AW), .INST_BYTES(SB), .UPC_W(UW), .RESET_VEC(RV)
   ) dut (
      .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_addr(load_addr),
      .adv_en(adv_en), .uadv_en(uadv_en), .uend_en(uend_en),
      .redir_en(redir_en), .redir_addr(redir_addr),
      .cur_pc(cur_pc), .nxt_pc(nxt_pc), .after_pc(after_pc),
      .cur_upc(cur_upc), .nxt_upc(nxt_upc), .branching(branching)
   );

   function automatic logic m_branch();
      logic seq_a;
      seq_a = (m_aft == m_nxt + AW'(SB)) &&
              ((m_nxt == m_cur + AW'(SB)) || (m_nxt == m_cur + AW'(2*SB)));
      return !(seq_a && (m_nu == m_cu + UW'(1)));
   endfunction

   function automatic logic [AW-1:0] rnd();
      seed = {seed[14:0], seed[15] ^ seed[13] ^ seed[12] ^ seed[10]};
      return seed[AW-1:0];
   endfunction

   task automatic check(input string req);
      logic eb;
      eb = m_branch();
      vectors++;
      if (cur_pc !== m_cur || nxt_pc !== m_nxt || after_pc !== m_aft ||
          cur_upc !== m_cu || nxt_upc !== m_nu || branching !== eb) begin
         fails++;
         $display("FAIL %s got %h %h %h u%0d/%0d b%b expected %h %h %h u%0d/%0d b%b",
                  req, cur_pc, nxt_pc, after_pc, cur_upc, nxt_upc, branching,
                  m_cur, m_nxt, m_aft, m_cu, m_nu, eb);
      end
   endtask

   // Apply one cycle of commands, update the model from the requirements, then compare
   task automatic step(input logic ld, input logic ue, input logic ad, input logic ua,
                       input logic rd, input logic [AW-1:0] la, input logic [AW-1:0] ra,
                       input string req);
      logic [AW-1:0] oc, on, oa;
      @(negedge clk);
      load_en = ld; uend_en = ue; adv_en = ad; uadv_en = ua; redir_en = rd;
      load_addr = la; redir_addr = ra;
      oc = m_cur; on = m_nxt; oa = m_aft;
      if (ld) begin                       // R1 R2 R8
         m_cur = la; m_nxt = la + AW'(SB); m_aft = la + AW'(2*SB);
         m_cu = '0; m_nu = UW'(1);
      end else begin
         if (ue || ad) begin              // R3 R5 R7
            m_cur = on; m_nxt = oa;
            m_aft = rd ? ra : oa + AW'(SB);
         end else if (rd) begin
            m_aft = ra;                   // R7
         end
         if (ue) begin
            m_cu = '0; m_nu = UW'(1);
         end else if (!ad && ua) begin    // R4 R8
            m_cu = m_nu; m_nu = m_nu + UW'(1);
         end
      end
      @(posedge clk);
      #1;
      load_en = 0; uend_en = 0; adv_en = 0; uadv_en = 0; redir_en = 0;
      check(req);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      m_cur = RV; m_nxt = RV + AW'(SB); m_aft = RV + AW'(2*SB);
      m_cu = '0; m_nu = UW'(1);
      #(CLK_PERIOD*2 + 1);
      check("R9 reset");
      @(negedge clk); rst_n = 1'b1;
      @(posedge clk); #1;
      check("R9 after release");
      step(0,0,0,0,0,'0,'0,"R9 idle hold");

      // R1 R2 R6: every load address
      for (int a = 0; a < 256; a++) step(1,0,0,0,0,AW'(a),'0,"R1 load sweep");

      // R3: sequential run with wrap
      step(1,0,0,0,0,8'hF0,'0,"R1 load");
      for (int i = 0; i < 20; i++) step(0,0,1,0,0,'0,'0,"R3 advance run");

      // R7: taken branch through the delay slot
      step(1,0,0,0,0,8'h40,'0,"R1 load");
      step(0,0,0,0,1,'0,8'h80,"R7 redirect alone");
      step(0,0,1,0,0,'0,'0,"R7 delay slot");
      step(0,0,1,0,0,'0,'0,"R7 branch target");
      step(0,0,1,0,1,'0,8'hC3,"R7 redirect with advance");
      step(0,0,1,0,0,'0,'0,"R6 odd target");
      step(0,0,1,0,0,'0,'0,"R6 resequenced");

      // R4 R5: micro-op sequences, including index wrap
      for (int n = 1; n < 11; n++) begin
         for (int k = 0; k < n; k++) step(0,0,0,1,0,'0,'0,"R4 micro-advance");
         step(0,1,0,0,0,'0,'0,"R5 micro-end");
      end
      for (int k = 0; k < 3; k++) step(0,0,0,1,0,'0,'0,"R4 micro-advance");
      step(0,1,0,0,1,'0,8'h22,"R5 micro-end with redirect");

      // R8: every command combination with varied addresses
      for (int rep = 0; rep < 12; rep++) begin
         for (int c = 0; c < 32; c++) begin
            step(c[0], c[1], c[2], c[3], c[4], rnd(), rnd(), "R8 combination");
         end
      end

      finish_run();
   end

endmodule